// File: doc/BRIEF.md
# Gshare conditional branch direction predictor

This block predicts at fetch whether a conditional branch is taken. It keeps a global history of recent conditional-branch outcomes and a table of 2-bit saturating counters. Each counter is selected by XORing the history with low bits of the branch's word address. The fetch side presents the word address, a flag marking a conditional branch, and the true outcome of that branch. The block returns its prediction in the same cycle. On the next clock edge it trains the selected counter and shifts the history with the true outcome. No speculative state is kept, so no history repair exists.

Branches that are not conditional never consult the table and never cost a bubble. When a conditional branch is mispredicted, a small stall controller holds fetch until the branch resolves. It then raises a redirect strobe for one cycle, during which the correct PC is loaded, and it releases fetch on the following cycle.

Top module: `gshare_bp`

## Requirements
- R1: After reset every counter holds binary 10 (weakly taken) and the history is all zeros, so every conditional branch is first predicted taken; stall_o and redirect_o are 0.
- R2: The counter index is fetch_word_pc_i XOR the HIST_W-bit history. Two branches that produce the same index share one counter.
- R3: pred_valid_o is 1 exactly when fetch_valid_i and fetch_cbr_i are both 1 and stall_o is 0. In that case pred_taken_o equals bit 1 of the selected counter (1 = taken).
- R4: On each valid prediction, the selected counter increments when fetch_taken_i is 1 and decrements when it is 0. It saturates at 11 and at 00, and takes effect at the next clock edge.
- R5: On each valid prediction the history shifts left by one bit and takes fetch_taken_i into bit 0. Otherwise the history holds.
- R6: A fetch with fetch_cbr_i = 0 changes no counter and no history, and it gives pred_valid_o = 0, mispredict_o = 0 and no stall.
- R7: mispredict_o is 1 when a valid prediction differs from fetch_taken_i. stall_o goes to 1 on the next cycle and stays 1 while resolve_i is 0.
- R8: resolve_i during a stall makes redirect_o 1 in the following cycle only, with stall_o still 1. stall_o returns to 0 in the cycle after redirect_o.
- R9: Fetches presented while stall_o is 1 produce no prediction and no misprediction, and they do not train the table or the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | A fetched instruction is presented |
| fetch_cbr_i | input | 1 | The instruction is a conditional branch |
| fetch_word_pc_i | input | HIST_W | Low bits of the word-aligned PC (PC bits HIST_W+1 down to 2) |
| fetch_taken_i | input | 1 | True outcome of the branch, used for training |
| resolve_i | input | 1 | The stalled branch resolved this cycle |
| pred_valid_o | output | 1 | A prediction is made this cycle |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| mispredict_o | output | 1 | Prediction differs from the true outcome |
| stall_o | output | 1 | Fetch must stall |
| redirect_o | output | 1 | Load the correct PC this cycle |

## Verification
Random branches come from a small pool of addresses, each with its own bias, mixed with random addresses. This makes counters saturate, the history vary, and aliasing occur between addresses whose index collides. Each prediction is compared with a bench model of the table and history. Directed runs of repeated not-taken and repeated taken outcomes hold the index fixed, which separates saturation at 00 and 11 from plain counting. A pair of addresses that differ only above the index bits shows that the two share one counter. Non-conditional fetches, and fetches during a stall, are followed by predictions that would show any unwanted training. Resolve pulses at random delays test the redirect and release timing.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b10;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOAD = 2'd2
  } stall_st_e;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  ctr_t ctr_q [DEPTH];
  ctr_t wr_val;

  assign wr_val   = ctr_next(ctr_q[wr_idx_i], wr_taken_i);
  assign rd_ctr_o = ctr_q[rd_idx_i];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ctr_q[e] <= CTR_INIT;
      else if (wr_en_i && (wr_idx_i == IDX_W'(e)))      ctr_q[e] <= wr_val;
    end
  end
endmodule

// File: rtl/gshare_stall.sv
module gshare_stall
  import gshare_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic miss_i,
  input  logic resolve_i,
  output logic stall_o,
  output logic redirect_o
);
  stall_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (miss_i)    st_d = ST_WAIT;
      ST_WAIT: if (resolve_i) st_d = ST_LOAD;
      ST_LOAD:                st_d = ST_RUN;
      default:                st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign stall_o    = (st_q != ST_RUN);
  assign redirect_o = (st_q == ST_LOAD);
endmodule

// File: rtl/gshare_bp.sv
module gshare_bp
  import gshare_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic              fetch_cbr_i,
  input  logic [HIST_W-1:0] fetch_word_pc_i,
  input  logic              fetch_taken_i,
  input  logic              resolve_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              mispredict_o,
  output logic              stall_o,
  output logic              redirect_o
);
  logic [HIST_W-1:0] ghr;
  logic [HIST_W-1:0] idx;
  ctr_t              ctr;
  logic              use_q;

  assign use_q = fetch_valid_i & fetch_cbr_i & ~stall_o;
  assign idx   = fetch_word_pc_i ^ ghr;

  gshare_hist #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (use_q),
    .taken_i (fetch_taken_i),
    .hist_o  (ghr)
  );

  gshare_pht #(.IDX_W(HIST_W)) u_pht (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_ctr_o   (ctr),
    .wr_en_i    (use_q),
    .wr_idx_i   (idx),
    .wr_taken_i (fetch_taken_i)
  );

  gshare_stall u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .miss_i     (mispredict_o),
    .resolve_i  (resolve_i),
    .stall_o    (stall_o),
    .redirect_o (redirect_o)
  );

  assign pred_valid_o = use_q;
  assign pred_taken_o = use_q & ctr[1];
  assign mispredict_o = use_q & (ctr[1] ^ fetch_taken_i);
endmodule

// File: rtl/gshare_bp_chk.sv
module gshare_bp_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              fetch_cbr_i,
  input logic              fetch_taken_i,
  input logic              resolve_i,
  input logic              pred_valid_o,
  input logic              mispredict_o,
  input logic              stall_o,
  input logic              redirect_o,
  input logic [HIST_W-1:0] ghr
);
  AST_MISS_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |=> stall_o); // R7
  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !redirect_o && !resolve_i) |=> (stall_o && !redirect_o)); // R7
  AST_RESOLVE_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !redirect_o && resolve_i) |=> (redirect_o && stall_o)); // R8
  AST_REDIRECT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !stall_o); // R8
  AST_QUIET_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!pred_valid_o && !mispredict_o)); // R9
  AST_NONCOND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !fetch_cbr_i) |-> (!pred_valid_o && !mispredict_o)); // R6
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |=> (ghr == {$past(ghr[HIST_W-2:0]), $past(fetch_taken_i)})); // R5
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |=> $stable(ghr)); // R5
endmodule

bind gshare_bp gshare_bp_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fetch_cbr_i   (fetch_cbr_i),
  .fetch_taken_i (fetch_taken_i),
  .resolve_i     (resolve_i),
  .pred_valid_o  (pred_valid_o),
  .mispredict_o  (mispredict_o),
  .stall_o       (stall_o),
  .redirect_o    (redirect_o),
  .ghr           (ghr)
);

// File: tb/sim_gshare_bp.sv
module sim_gshare_bp;
  localparam int H = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         fetch_valid_i = 1'b0;
  logic         fetch_cbr_i = 1'b0;
  logic [H-1:0] fetch_word_pc_i = '0;
  logic         fetch_taken_i = 1'b0;
  logic         resolve_i = 1'b0;
  logic         pred_valid_o, pred_taken_o, mispredict_o, stall_o, redirect_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0]   m_ctr [1<<H];
  logic [H-1:0] m_ghr;
  int           m_st;

  always #2 clk_i = ~clk_i;

  gshare_bp #(.HIST_W(H)) u0 (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] m_next(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic [H-1:0] wpc(logic [31:0] pc);
    return pc[H+1:2];
  endfunction

  task automatic step(input logic v, input logic cbr, input logic [31:0] pc,
                      input logic t, input logic res);
    logic         eff, ep, em;
    logic [H-1:0] ix;
    @(negedge clk_i);
    fetch_valid_i   = v;
    fetch_cbr_i     = cbr;
    fetch_word_pc_i = wpc(pc);
    fetch_taken_i   = t;
    resolve_i       = res;
    #1;
    eff = v & cbr & (m_st == 0);
    ix  = wpc(pc) ^ m_ghr;
    ep  = m_ctr[ix][1];
    em  = eff & (ep != t);
    chk(pred_valid_o == eff, "R3 R6 R9 pred_valid", pred_valid_o, eff);
    if (eff) chk(pred_taken_o == ep, "R1 R2 R3 R4 R5 pred_taken", pred_taken_o, ep);
    chk(mispredict_o == em, "R7 R9 mispredict", mispredict_o, em);
    chk(stall_o == (m_st != 0), "R7 R8 stall", stall_o, m_st != 0);
    chk(redirect_o == (m_st == 2), "R8 redirect", redirect_o, m_st == 2);
    @(posedge clk_i);
    if (eff) begin
      m_ctr[ix] = m_next(m_ctr[ix], t);
      m_ghr     = {m_ghr[H-2:0], t};
    end
    case (m_st)
      0: if (em) m_st = 1;
      1: if (res) m_st = 2;
      default: m_st = 0;
    endcase
  endtask

  task automatic drain();
    while (m_st != 0) step(1'b0, 1'b0, 32'h0, 1'b0, m_st == 1);
  endtask

  initial begin
    #150000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] pool [6];
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < (1 << H); i++) m_ctr[i] = 2'b10;
    m_ghr = '0;
    m_st  = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state, first predictions taken
    chk(stall_o == 1'b0, "R1 stall at reset", stall_o, 0);
    chk(redirect_o == 1'b0, "R1 redirect at reset", redirect_o, 0);
    step(1'b1, 1'b1, 32'h0000_0100, 1'b1, 1'b0);
    step(1'b1, 1'b1, 32'h0000_0344, 1'b1, 1'b0);

    // R6: non-conditional fetches leave state alone
    repeat (4) step(1'b1, 1'b0, 32'h0000_0100, 1'b0, 1'b0);
    step(1'b1, 1'b1, 32'h0000_0100, 1'b1, 1'b0);

    // R4: force history to zeros, then saturate at 00
    repeat (H) begin step(1'b1, 1'b1, 32'h0000_0200, 1'b0, 1'b0); drain(); end
    repeat (4) begin step(1'b1, 1'b1, 32'h0000_0200, 1'b0, 1'b0); drain(); end
    // R2: alias above index bits shares the counter
    step(1'b1, 1'b1, 32'h0000_0200 + (32'h1 << (H+2)), 1'b0, 1'b0);
    drain();

    // R4: all-ones history, saturate at 11
    repeat (H + 4) begin step(1'b1, 1'b1, 32'h0000_0480, 1'b1, 1'b0); drain(); end
    step(1'b1, 1'b1, 32'h0000_0480 + (32'h3 << (H+2)), 1'b1, 1'b0);
    drain();

    // R7 R8 R9: long stall with fetches offered inside it
    step(1'b1, 1'b1, 32'h0000_0480, 1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b1, 32'h0000_0480, 1'b0, 1'b0);
    step(1'b1, 1'b1, 32'h0000_0480, 1'b0, 1'b1);
    step(1'b1, 1'b1, 32'h0000_0480, 1'b0, 1'b1);
    step(1'b1, 1'b1, 32'h0000_0480, 1'b1, 1'b0);
    drain();

    // random mix
    pool = '{32'h0000_1000, 32'h0000_1004, 32'h0000_2400,
             32'h0000_1400, 32'h0000_3008, 32'h0000_0ffc};
    for (int n = 0; n < 4000; n++) begin
      int unsigned r, k;
      logic [31:0] pc;
      logic t;
      r  = $urandom;
      k  = r % 7;
      pc = (k < 6) ? pool[k] : ($urandom & 32'hffff_fffc);
      case (k)
        0: t = 1'b1;
        1: t = 1'b0;
        2: t = ((r >> 4) % 4) != 0;
        3: t = ((r >> 4) % 4) == 0;
        default: t = r[9];
      endcase
      step(((r >> 12) % 8) != 0, ((r >> 16) % 5) != 0, pc, t,
           (m_st == 1) && (((r >> 20) % 4) == 0));
    end
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule